// File: doc/BRIEF.md
# Predicated Element Loop Sequencer

This block is the hardware loop that walks one prefixed vector operation across its elements. A start strobe captures the element count, a two-bit sub-vector length code, a three-bit predicate selector with a single/twin mode bit, scalar/vector flags for the source and destination operands, the two base register numbers and the contents of the three predicate registers. The block then emits one element issue per clock. Each issue carries the source and destination register numbers, the source and destination element indices and the sub-element index. The loop ends with a one-cycle done pulse.

Elements that the predicate turns off are skipped in the same cycle, so no issue cycle is spent on them. Each enabled element occupies as many consecutive cycles as the sub-vector length. In twin mode the source and destination walk their own element indices, each gated by its own predicate register. This is how a scalar can be spread over selected destination elements, or how one selected element can be pulled into a scalar. The ALUs, the register file and the packing of narrow elements all sit outside the block.

Top module: `elem_loop_seq`

## Requirements
- R1: After a synchronous active-low reset, busy, issue_vld, done and illegal are all 0.
- R2: When idle, a start pulse latches every loop input and raises busy on the next cycle. A start pulse that arrives while busy is 1 is ignored, and the running loop continues with its original settings.
- R3: A scalar operand (its vector flag is 0) presents its base register number unchanged on every issue cycle.
- R4: A vector operand presents its base register number plus its current element index, modulo 2^REG_W.
- R5: The sub-vector length code maps 00 to 1, 01 to 2, 10 to 3 and 11 to 4. Each enabled element issues that many consecutive cycles, with issue_sub counting up from 0 and the register numbers and indices held steady.
- R6: Single-mode predicate codes work as follows. 000 enables every element. 010/011 select predicate register A, 100/101 select register B and 110/111 select register C. Bit 0 of the code set means an element runs when its predicate bit is 1; bit 0 clear means it runs when its predicate bit is 0. A predicate bit gates a whole sub-vector group, and disabled elements produce no issue cycle.
- R7: In twin mode, code bit 0 gates source elements with register A and code bit 1 gates destination elements with register B, and code bit 2 inverts both. A side whose gating bit is 0 is unpredicated, so code 100 is fully unpredicated. Each side steps to its own next enabled element after every group, and the loop ends when either side runs out.
- R8: The loop ends after the first issued group in two cases: the destination is scalar in single mode with a nonzero code, or, in twin mode, a scalar side has its predicate enabled.
- R9: done is 1 for exactly one cycle: the cycle after the last issue cycle, or the first busy cycle if no element is enabled. busy is 0 in the following cycle. done, issue_vld and illegal are never 1 while busy is 0.
- R10: The single-mode code 001 is reserved. Such a loop issues nothing, and illegal and done are both 1 in its first busy cycle.
- R11: Only element indices below min(vl_in, MAX_VL) take part. A count of 0 ends the loop at once with no issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Start strobe, taken only while idle |
| twin_mode | input | 1 | 1 = twin (source/destination) predication |
| pred_code | input | 3 | Predicate selector code |
| sub_code | input | 2 | Sub-vector length code |
| vl_in | input | PTR_W | Element count |
| src_vec | input | 1 | Source operand is a vector |
| dst_vec | input | 1 | Destination operand is a vector |
| src_base | input | REG_W | Source base register number |
| dst_base | input | REG_W | Destination base register number |
| pred_reg_a | input | MAX_VL | Predicate register A contents |
| pred_reg_b | input | MAX_VL | Predicate register B contents |
| pred_reg_c | input | MAX_VL | Predicate register C contents |
| busy | output | 1 | Loop active |
| issue_vld | output | 1 | An element issue is presented this cycle |
| issue_src | output | REG_W | Source register number |
| issue_dst | output | REG_W | Destination register number |
| issue_sidx | output | IDX_W | Source element index |
| issue_didx | output | IDX_W | Destination element index |
| issue_sub | output | 2 | Sub-element index within the group |
| done | output | 1 | One-cycle end-of-loop pulse |
| illegal | output | 1 | Reserved predicate code seen (with done) |

## Verification
The issue outputs come straight from the loop state, so a wrong pointer, sub-element counter or latched mask shows up in the same cycle. It appears as a wrong register number, a wrong index, an issue cycle that should have been skipped, or a done pulse that comes early or late. A stop flag or busy bit that is set wrongly shows up no later than the next cycle, as a missing done, a loop that never ends, or an extra issue after done. The bench sweeps every code, length and operand-kind combination against a cycle-by-cycle model and compares every busy cycle, so any such divergence is caught at the first cycle it reaches the ports.

// File: rtl/els_pkg.sv
// Package: shared constants and encodings for the element loop sequencer.
// Assumes: predicate codes are three bits; sub-vector length codes are two bits.
package els_pkg;

    // Single-mode predicate code values with a fixed meaning
    localparam logic [2:0] PC_NONE     = 3'b000;
    localparam logic [2:0] PC_RESERVED = 3'b001;

    // Twin-mode predicate code bit roles
    localparam int TW_SRC_BIT = 0;
    localparam int TW_DST_BIT = 1;
    localparam int TW_INV_BIT = 2;

    // Last sub-element index for a sub-vector length code (length minus one)
    function automatic logic [1:0] sub_last(input logic [1:0] code);
        return code;
    endfunction

endpackage

// File: rtl/els_mask_gen.sv
// Module: els_mask_gen
// Turns the predicate selector, the mode bit and the element count into one
// enable mask per operand side, plus the reserved-code and one-shot flags.
// Assumes: MAX_VL predicate bits per register; element i maps to bit i.
module els_mask_gen
    import els_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int PTR_W  = $clog2(MAX_VL + 1)
) (
    input  logic              twin_mode,
    input  logic [2:0]        pred_code,
    input  logic [PTR_W-1:0]  vl_eff,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [MAX_VL-1:0] reg_a,
    input  logic [MAX_VL-1:0] reg_b,
    input  logic [MAX_VL-1:0] reg_c,
    output logic [MAX_VL-1:0] src_mask,
    output logic [MAX_VL-1:0] dst_mask,
    output logic              code_illegal,
    output logic              one_shot
);

    logic src_gated;
    logic dst_gated;
    logic inv;

    assign inv       = pred_code[TW_INV_BIT];
    assign src_gated = pred_code[TW_SRC_BIT];
    assign dst_gated = pred_code[TW_DST_BIT];

    // Purpose: reserved code detection (single mode only)
    assign code_illegal = !twin_mode && (pred_code == PC_RESERVED);

    // Purpose: decide whether a scalar side stops the loop after one group
    always_comb begin
        if (twin_mode) begin
            one_shot = (!src_vec && src_gated) || (!dst_vec && dst_gated);
        end else begin
            one_shot = !dst_vec && (pred_code != PC_NONE);
        end
    end

    // Purpose: build per-element enables for both sides, limited to the count
    always_comb begin
        for (int i = 0; i < MAX_VL; i++) begin
            logic in_range;
            logic s_en;
            logic d_en;
            in_range = (i < int'(vl_eff));
            if (twin_mode) begin
                s_en = src_gated ? (reg_a[i] ^ inv) : 1'b1;
                d_en = dst_gated ? (reg_b[i] ^ inv) : 1'b1;
            end else begin
                case (pred_code[2:1])
                    2'b00:   s_en = !pred_code[0];
                    2'b01:   s_en = (reg_a[i] == pred_code[0]);
                    2'b10:   s_en = (reg_b[i] == pred_code[0]);
                    default: s_en = (reg_c[i] == pred_code[0]);
                endcase
                d_en = s_en;
            end
            src_mask[i] = in_range && s_en;
            dst_mask[i] = in_range && d_en;
        end
    end

endmodule

// File: rtl/els_scan.sv
// Module: els_scan
// Finds the lowest set mask bit at or above a start pointer.
// Assumes: pointer may equal N (nothing left); purely combinational.
module els_scan #(
    parameter int N     = 64,
    parameter int PTR_W = $clog2(N + 1),
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     mask,
    input  logic [PTR_W-1:0] from,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    // Purpose: priority search, the lowest qualifying bit wins
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i] && (i >= int'(from))) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/els_reg_map.sv
// Module: els_reg_map
// Maps an operand base register and element index to the register number
// handed out: scalars keep the base, vectors add the index (wrapping).
// Assumes: IDX_W is not wider than REG_W in normal use.
module els_reg_map #(
    parameter int REG_W = 7,
    parameter int IDX_W = 6
) (
    input  logic [REG_W-1:0] base,
    input  logic             is_vec,
    input  logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] reg_num
);

    // Purpose: select fixed or stepping register number
    assign reg_num = is_vec ? (base + REG_W'(idx)) : base;

endmodule

// File: rtl/elem_loop_seq.sv
// Module: elem_loop_seq
// Hardware element loop. It latches the operation settings on start, then issues
// one element group per cycle run, skipping disabled elements in zero cycles,
// and pulses done once the loop is exhausted.
// Assumes: outputs are decoded from registered state; start is ignored while busy.
module elem_loop_seq
    import els_pkg::*;
#(
    parameter int MAX_VL = 64,
    parameter int REG_W  = 7,
    parameter int PTR_W  = $clog2(MAX_VL + 1),
    parameter int IDX_W  = $clog2(MAX_VL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              twin_mode,
    input  logic [2:0]        pred_code,
    input  logic [1:0]        sub_code,
    input  logic [PTR_W-1:0]  vl_in,
    input  logic              src_vec,
    input  logic              dst_vec,
    input  logic [REG_W-1:0]  src_base,
    input  logic [REG_W-1:0]  dst_base,
    input  logic [MAX_VL-1:0] pred_reg_a,
    input  logic [MAX_VL-1:0] pred_reg_b,
    input  logic [MAX_VL-1:0] pred_reg_c,
    output logic              busy,
    output logic              issue_vld,
    output logic [REG_W-1:0]  issue_src,
    output logic [REG_W-1:0]  issue_dst,
    output logic [IDX_W-1:0]  issue_sidx,
    output logic [IDX_W-1:0]  issue_didx,
    output logic [1:0]        issue_sub,
    output logic              done,
    output logic              illegal
);

    localparam logic [PTR_W-1:0] VL_CAP = PTR_W'(MAX_VL);

    // Start-time decode results
    logic [PTR_W-1:0]  vl_eff;
    logic [MAX_VL-1:0] src_mask_d;
    logic [MAX_VL-1:0] dst_mask_d;
    logic              ill_d;
    logic              one_shot_d;

    // Latched loop settings
    logic              busy_q;
    logic [MAX_VL-1:0] src_mask_q;
    logic [MAX_VL-1:0] dst_mask_q;
    logic [REG_W-1:0]  src_base_q;
    logic [REG_W-1:0]  dst_base_q;
    logic              src_vec_q;
    logic              dst_vec_q;
    logic [1:0]        sub_last_q;
    logic              one_shot_q;
    logic              ill_q;

    // Loop progress
    logic [PTR_W-1:0]  src_ptr_q;
    logic [PTR_W-1:0]  dst_ptr_q;
    logic [1:0]        sub_q;
    logic              stop_q;

    // Scan results
    logic              src_found;
    logic              dst_found;
    logic [IDX_W-1:0]  src_idx;
    logic [IDX_W-1:0]  dst_idx;
    logic              fire;
    logic              group_end;

    // Purpose: clamp the requested element count to the hardware limit
    assign vl_eff = (vl_in > VL_CAP) ? VL_CAP : vl_in;

    els_mask_gen #(
        .MAX_VL (MAX_VL),
        .PTR_W  (PTR_W)
    ) i_mask_gen (
        .twin_mode    (twin_mode),
        .pred_code    (pred_code),
        .vl_eff       (vl_eff),
        .src_vec      (src_vec),
        .dst_vec      (dst_vec),
        .reg_a        (pred_reg_a),
        .reg_b        (pred_reg_b),
        .reg_c        (pred_reg_c),
        .src_mask     (src_mask_d),
        .dst_mask     (dst_mask_d),
        .code_illegal (ill_d),
        .one_shot     (one_shot_d)
    );

    els_scan #(
        .N     (MAX_VL),
        .PTR_W (PTR_W),
        .IDX_W (IDX_W)
    ) i_scan_src (
        .mask  (src_mask_q),
        .from  (src_ptr_q),
        .found (src_found),
        .idx   (src_idx)
    );

    els_scan #(
        .N     (MAX_VL),
        .PTR_W (PTR_W),
        .IDX_W (IDX_W)
    ) i_scan_dst (
        .mask  (dst_mask_q),
        .from  (dst_ptr_q),
        .found (dst_found),
        .idx   (dst_idx)
    );

    els_reg_map #(
        .REG_W (REG_W),
        .IDX_W (IDX_W)
    ) i_map_src (
        .base    (src_base_q),
        .is_vec  (src_vec_q),
        .idx     (src_idx),
        .reg_num (issue_src)
    );

    els_reg_map #(
        .REG_W (REG_W),
        .IDX_W (IDX_W)
    ) i_map_dst (
        .base    (dst_base_q),
        .is_vec  (dst_vec_q),
        .idx     (dst_idx),
        .reg_num (issue_dst)
    );

    // Purpose: an issue happens when both sides have an element and no stop is pending
    assign fire      = busy_q && src_found && dst_found && !stop_q;
    assign group_end = (sub_q == sub_last_q);

    // Purpose: drive the outputs from the registered state
    assign busy       = busy_q;
    assign issue_vld  = fire;
    assign issue_sidx = src_idx;
    assign issue_didx = dst_idx;
    assign issue_sub  = sub_q;
    assign done       = busy_q && !fire;
    assign illegal    = busy_q && !fire && ill_q;

    // Purpose: capture the loop settings when an idle start arrives
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_mask_q <= '0;
            dst_mask_q <= '0;
            src_base_q <= '0;
            dst_base_q <= '0;
            src_vec_q  <= 1'b0;
            dst_vec_q  <= 1'b0;
            sub_last_q <= '0;
            one_shot_q <= 1'b0;
            ill_q      <= 1'b0;
        end else if (start && !busy_q) begin
            src_mask_q <= src_mask_d;
            dst_mask_q <= dst_mask_d;
            src_base_q <= src_base;
            dst_base_q <= dst_base;
            src_vec_q  <= src_vec;
            dst_vec_q  <= dst_vec;
            sub_last_q <= sub_last(sub_code);
            one_shot_q <= one_shot_d;
            ill_q      <= ill_d;
        end
    end

    // Purpose: loop busy flag, set by start and cleared on the done cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
        end else if (!busy_q) begin
            busy_q <= start;
        end else begin
            busy_q <= fire;
        end
    end

    // Purpose: advance the pointers and the sub-element counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_ptr_q <= '0;
            dst_ptr_q <= '0;
            sub_q     <= '0;
            stop_q    <= 1'b0;
        end else if (start && !busy_q) begin
            src_ptr_q <= '0;
            dst_ptr_q <= '0;
            sub_q     <= '0;
            stop_q    <= 1'b0;
        end else if (fire) begin
            if (group_end) begin
                sub_q     <= '0;
                src_ptr_q <= PTR_W'(src_idx) + PTR_W'(1);
                dst_ptr_q <= PTR_W'(dst_idx) + PTR_W'(1);
                stop_q    <= one_shot_q;
            end else begin
                sub_q <= sub_q + 2'd1;
            end
        end
    end

endmodule

// File: rtl/els_checker.sv
// Module: els_checker
// Temporal checks on the sequencer ports, attached by bind.
// Assumes: synchronous active-low reset; all checks are disabled during reset.
module els_checker #(
    parameter int REG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             busy,
    input logic             issue_vld,
    input logic [REG_W-1:0] issue_src,
    input logic [REG_W-1:0] issue_dst,
    input logic [1:0]       issue_sub,
    input logic             done,
    input logic             illegal
);

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!issue_vld && !done && !illegal)); // R9

    AST_DONE_ENDS_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R9

    AST_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy); // R2

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy); // R2

    AST_ILLEGAL_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> (done && !issue_vld)); // R10

    AST_SUB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_sub != 2'd0) |->
            ($past(issue_vld) && issue_sub == $past(issue_sub) + 2'd1)); // R5

    AST_SUB_REGS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && issue_sub != 2'd0) |->
            ($stable(issue_src) && $stable(issue_dst))); // R5

    AST_GROUP_STARTS_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_vld && !$past(issue_vld)) |-> (issue_sub == 2'd0)); // R5

endmodule

bind elem_loop_seq els_checker #(
    .REG_W (REG_W)
) i_els_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .issue_vld (issue_vld),
    .issue_src (issue_src),
    .issue_dst (issue_dst),
    .issue_sub (issue_sub),
    .done      (done),
    .illegal   (illegal)
);

// File: tb/test_elem_loop_seq.sv
// Bench: sweeps every mode, code, length and operand kind over two predicate
// patterns and several element counts, comparing each busy cycle with a model.
module test_elem_loop_seq;

    localparam int MAX_VL = 64;
    localparam int REG_W  = 7;
    localparam int PTR_W  = 7;
    localparam int IDX_W  = 6;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              start;
    logic              twin_mode;
    logic [2:0]        pred_code;
    logic [1:0]        sub_code;
    logic [PTR_W-1:0]  vl_in;
    logic              src_vec;
    logic              dst_vec;
    logic [REG_W-1:0]  src_base;
    logic [REG_W-1:0]  dst_base;
    logic [MAX_VL-1:0] pred_reg_a;
    logic [MAX_VL-1:0] pred_reg_b;
    logic [MAX_VL-1:0] pred_reg_c;
    logic              busy;
    logic              issue_vld;
    logic [REG_W-1:0]  issue_src;
    logic [REG_W-1:0]  issue_dst;
    logic [IDX_W-1:0]  issue_sidx;
    logic [IDX_W-1:0]  issue_didx;
    logic [1:0]        issue_sub;
    logic              done;
    logic              illegal;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    elem_loop_seq #(
        .MAX_VL (MAX_VL),
        .REG_W  (REG_W)
    ) i_elem_loop_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .twin_mode  (twin_mode),
        .pred_code  (pred_code),
        .sub_code   (sub_code),
        .vl_in      (vl_in),
        .src_vec    (src_vec),
        .dst_vec    (dst_vec),
        .src_base   (src_base),
        .dst_base   (dst_base),
        .pred_reg_a (pred_reg_a),
        .pred_reg_b (pred_reg_b),
        .pred_reg_c (pred_reg_c),
        .busy       (busy),
        .issue_vld  (issue_vld),
        .issue_src  (issue_src),
        .issue_dst  (issue_dst),
        .issue_sidx (issue_sidx),
        .issue_didx (issue_didx),
        .issue_sub  (issue_sub),
        .done       (done),
        .illegal    (illegal)
    );

    // Watchdog: a hung run counts as a failed check
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            errors = errors + 1;
            $display("FAIL R9 watchdog: actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One loop: drive the settings, start, then compare every busy cycle with the model
    task automatic run_case(input bit tw, input logic [2:0] pc, input logic [1:0] sc,
                            input bit sv, input bit dv, input logic [6:0] sb,
                            input logic [6:0] db, input logic [6:0] vl,
                            input logic [63:0] pa, input logic [63:0] pb,
                            input logic [63:0] pcr, input bit poke);
        bit sm [64];
        bit dm [64];
        int vlim;
        bit ill;
        bit oneshot;
        int sp;
        int dp;
        int sub;
        bit stop;
        int last;
        vlim = (int'(vl) > MAX_VL) ? MAX_VL : int'(vl);
        ill = !tw && (pc == 3'b001);
        oneshot = tw ? ((!sv && pc[0]) || (!dv && pc[1])) : (!dv && pc != 3'b000);
        last = int'(sc);
        for (int i = 0; i < 64; i++) begin
            bit m;
            if (!tw) begin
                case (pc)
                    3'd0: m = 1'b1;
                    3'd1: m = 1'b0;
                    3'd2, 3'd3: m = (pa[i] == pc[0]);
                    3'd4, 3'd5: m = (pb[i] == pc[0]);
                    default: m = (pcr[i] == pc[0]);
                endcase
                sm[i] = m && (i < vlim);
                dm[i] = m && (i < vlim);
            end else begin
                sm[i] = (pc[0] ? (pa[i] ^ pc[2]) : 1'b1) && (i < vlim);
                dm[i] = (pc[1] ? (pb[i] ^ pc[2]) : 1'b1) && (i < vlim);
            end
        end
        @(negedge clk);
        twin_mode = tw; pred_code = pc; sub_code = sc; vl_in = vl;
        src_vec = sv; dst_vec = dv; src_base = sb; dst_base = db;
        pred_reg_a = pa; pred_reg_b = pb; pred_reg_c = pcr;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        sp = 0; dp = 0; sub = 0; stop = 1'b0;
        for (int cyc = 0; cyc < 400; cyc++) begin
            int si;
            int di;
            bit term;
            si = -1; di = -1;
            for (int i = 63; i >= 0; i--) begin
                if (sm[i] && i >= sp) si = i;
                if (dm[i] && i >= dp) di = i;
            end
            term = stop || si < 0 || di < 0;
            check(poke ? "R2 busy" : "R9 busy", 32'(busy), 32'd1);
            if (!term) begin
                logic [6:0] es;
                logic [6:0] ed;
                es = sv ? 7'(int'(sb) + si) : sb;
                ed = dv ? 7'(int'(db) + di) : db;
                check(tw ? "R7 issue" : "R6 issue", 32'(issue_vld), 32'd1);
                check(sv ? "R4 src reg" : "R3 src reg", 32'(issue_src), 32'(es));
                check(dv ? "R4 dst reg" : "R3 dst reg", 32'(issue_dst), 32'(ed));
                check(tw ? "R7 src index" : "R6 src index", 32'(issue_sidx), 32'(si));
                check(tw ? "R7 dst index" : "R6 dst index", 32'(issue_didx), 32'(di));
                check("R5 sub index", 32'(issue_sub), 32'(sub));
                check("R9 no early done", 32'(done), 32'd0);
                if (sub == last) begin
                    sub = 0; sp = si + 1; dp = di + 1;
                    if (oneshot) stop = 1'b1;
                end else begin
                    sub = sub + 1;
                end
            end else begin
                check(oneshot ? "R8 stop" : (tw ? "R7 end" : "R11 end"), 32'(issue_vld), 32'd0);
                check("R9 done", 32'(done), 32'd1);
                check("R10 illegal", 32'(illegal), 32'(ill));
            end
            if (poke && cyc == 1) begin
                start = 1'b1;
                src_base = sb ^ 7'h55;
                dst_base = db ^ 7'h2A;
                src_vec = !sv;
                sub_code = ~sc;
            end else if (poke && cyc == 2) begin
                start = 1'b0;
            end
            if (term) break;
            @(negedge clk);
        end
        start = 1'b0;
        @(negedge clk);
        check("R9 busy drops", 32'({busy, done, issue_vld}), 32'd0);
    endtask

    initial begin
        start = 1'b0; twin_mode = 1'b0; pred_code = '0; sub_code = '0; vl_in = '0;
        src_vec = 1'b0; dst_vec = 1'b0; src_base = '0; dst_base = '0;
        pred_reg_a = '0; pred_reg_b = '0; pred_reg_c = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset state", 32'({busy, issue_vld, done, illegal}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", 32'({busy, issue_vld, done, illegal}), 32'd0);

        // R11: empty and over-long counts
        run_case(1'b0, 3'b000, 2'b00, 1'b1, 1'b1, 7'd10, 7'd20, 7'd0,
                 64'h0, 64'h0, 64'h0, 1'b0);
        run_case(1'b0, 3'b000, 2'b01, 1'b1, 1'b1, 7'd10, 7'd20, 7'd100,
                 64'h0, 64'h0, 64'h0, 1'b0);
        // R2: start while busy is ignored
        run_case(1'b0, 3'b011, 2'b10, 1'b1, 1'b1, 7'd30, 7'd90, 7'd12,
                 64'hFFFF_0000_0F0F_0AF5, 64'h0, 64'h0, 1'b1);
        run_case(1'b1, 3'b011, 2'b01, 1'b1, 1'b1, 7'd1, 7'd2, 7'd16,
                 64'h0000_0000_0000_5A5A, 64'h0000_0000_0000_C3C3, 64'h0, 1'b1);

        // Sweep: mode, code, sub length, operand kinds, patterns, counts
        for (int tw = 0; tw < 2; tw++)
            for (int pc = 0; pc < 8; pc++)
                for (int sc = 0; sc < 4; sc++)
                    for (int fl = 0; fl < 4; fl++)
                        for (int pat = 0; pat < 2; pat++)
                            for (int v = 0; v < 3; v++) begin
                                logic [6:0] vlv;
                                vlv = (v == 0) ? 7'd1 : ((v == 1) ? 7'd9 : 7'd64);
                                if (pat == 0)
                                    run_case(tw[0], 3'(pc), 2'(sc), fl[0], fl[1], 7'd120, 7'd5, vlv,
                                             64'hA5C3_0F96_1234_8001, 64'h0F0F_00FF_3C3C_0110,
                                             64'h8000_0000_0000_0003, 1'b0);
                                else
                                    run_case(tw[0], 3'(pc), 2'(sc), fl[0], fl[1], 7'd3, 7'd100, vlv,
                                             64'h0, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
                            end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule